// File: doc/BRIEF.md
# Password-Gated Vote Tally Unit

This block keeps a running tally for a small fixed field of candidates (four by default) and, once polling is closed, reports who leads. Nothing it receives counts until a 32-bit key has been presented and matches the value fixed at build time. Repeated wrong keys lock the unit out until the next reset.

A ballot is a pulse on the cast input. While the pulse is high, the candidate selection is sampled. When the pulse falls, one vote is committed for the candidate chosen in the last high cycle. A selection that does not name exactly one candidate is refused and counted as an invalid attempt. When the close input is accepted, the tallies freeze. From the next cycle on, registered result flags mark every candidate that holds the top count. A separate tie flag rises when two or more candidates share that count.

Top module: `vote_tally_unit`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every tally and the invalid counter. It relocks the unit, clears the lockout and failure history, reopens polling, and drives winner, tie and result_valid low.
- R2: With the unit locked and not locked out, a cycle with key_valid high and key_word equal to KEY makes unlocked read 1 after that edge.
- R3: Each key attempt that does not match, made while locked, adds one to a consecutive-failure count, and a correct key clears that count. When the count reaches MAX_TRIES (3 by default), lockout goes high and stays high until reset. While lockout is high, unlocked stays 0, even for a correct key.
- R4: While unlocked is 0, cast pulses and close requests change no tally, leave the invalid counter unchanged and produce no result.
- R5: A vote is committed at the first clock edge at which cast is sampled low after having been sampled high. It uses the selection sampled in the last cycle cast was high, and the new tally is visible after that edge.
- R6: A cast pulse adds at most one vote, however many cycles it stays high.
- R7: Bit i of sel selects candidate i. A committed pulse whose selection has zero bits or more than one bit set leaves all tallies unchanged and adds one to invalid_count, which saturates at its all-ones value.
- R8: Each tally is CNT_W bits (16 by default). A tally at its all-ones value stays there on further votes.
- R9: A close request is accepted while unlocked. From that edge on, polling stays closed until reset: tallies and invalid_count are frozen, and a pulse falling in the same cycle as the accepted request is also ignored.
- R10: result_valid, winner and tie are 0 while polling is open. After the edge that accepts the close request, result_valid is 1 and winner bit i is 1 exactly when tally i equals the largest tally. tie is 1 exactly when two or more winner bits are set, including the all-zero case.
- R11: Once unlocked, key attempts are ignored: unlocked stays 1, and a wrong key does not lead to lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_valid | input | 1 | Key attempt strobe |
| key_word | input | KEY_W (32) | Key presented with the strobe |
| cast | input | 1 | Ballot pulse; vote commits on its falling edge |
| sel | input | N_CAND | One-hot candidate selection |
| close_req | input | 1 | Request to end polling |
| unlocked | output | 1 | Correct key accepted |
| lockout | output | 1 | Sticky too-many-failures flag |
| vote_counts | output | N_CAND*CNT_W | Tallies, candidate i at bits [i*CNT_W +: CNT_W] |
| invalid_count | output | INV_W | Refused-selection counter |
| winner | output | N_CAND | One flag per candidate holding the top tally |
| tie | output | 1 | Top tally shared by two or more candidates |
| result_valid | output | 1 | Results are meaningful |

## Verification
Tallies are driven with short pulses, a pulse held for several cycles, and a pulse whose selection changes while high. These separate counting on the falling edge from counting every high cycle, and show which sampled selection is used. Empty and multi-bit selections and a run long enough to saturate a narrowed tally probe the refusal and clamp paths. Four closing scenarios are tried: one clear leader, a two-way tie, all tallies zero, and closing with pulses still arriving. Together they separate a single winner, a shared lead and the frozen state. Key sequences of wrong-wrong-right, three straight wrongs, and wrong keys after unlock test the consecutive-failure rule and the sticky lockout.

// File: rtl/vtu_pkg.sv
package vtu_pkg;
    localparam logic [31:0] DEF_KEY = 32'hC0DE_5A17;

    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_VOTE   = 2'd1,
        ACT_REFUSE = 2'd2
    } ballot_act_e;
endpackage

// File: rtl/vtu_key_gate.sv
module vtu_key_gate #(
    parameter int          KEY_W     = 32,
    parameter logic [KEY_W-1:0] KEY  = vtu_pkg::DEF_KEY,
    parameter int          MAX_TRIES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_valid,
    input  logic [KEY_W-1:0] key_word,
    output logic             unlocked,
    output logic             lockout
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);
    localparam logic [TRY_W-1:0] TRY_LIM = TRY_W'(MAX_TRIES);

    typedef struct packed {
        logic             open;
        logic             barred;
        logic [TRY_W-1:0] fails;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key_valid && !st_q.open && !st_q.barred) begin
            if (key_word == KEY) begin
                st_d.open  = 1'b1;
                st_d.fails = '0;
            end else begin
                st_d.fails = st_q.fails + 1'b1;
                if (st_d.fails >= TRY_LIM) begin
                    st_d.barred = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign unlocked = st_q.open;
    assign lockout  = st_q.barred;

    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        lockout |=> lockout);
    p_lock_excl_r3: assert property (@(posedge clk) disable iff (rst)
        lockout |-> !unlocked);
    p_unlock_key_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(key_valid && key_word == KEY));
    p_stay_open_r11: assert property (@(posedge clk) disable iff (rst)
        unlocked |=> unlocked);
endmodule

// File: rtl/vtu_ballot.sv
module vtu_ballot #(
    parameter int N_CAND = 4,
    parameter int CNT_W  = 16,
    parameter int INV_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         accept,
    input  logic                         cast,
    input  logic [N_CAND-1:0]            sel,
    output logic [N_CAND-1:0][CNT_W-1:0] counts,
    output logic [INV_W-1:0]             invalid_count
);
    import vtu_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [INV_W-1:0] INV_MAX = '1;

    typedef struct packed {
        logic                         cast_q;
        logic [N_CAND-1:0]            hold;
        logic [N_CAND-1:0][CNT_W-1:0] tally;
        logic [INV_W-1:0]             refused;
    } ballot_t;

    ballot_t     st_d, st_q;
    ballot_act_e act;
    logic        fall;

    assign fall = st_q.cast_q && !cast;

    always_comb begin
        if (!(fall && accept)) begin
            act = ACT_IDLE;
        end else if ($onehot(st_q.hold)) begin
            act = ACT_VOTE;
        end else begin
            act = ACT_REFUSE;
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.cast_q = cast;
        if (cast) begin
            st_d.hold = sel;
        end
        for (int i = 0; i < N_CAND; i++) begin
            if (act == ACT_VOTE && st_q.hold[i] && st_q.tally[i] != CNT_MAX) begin
                st_d.tally[i] = st_q.tally[i] + 1'b1;
            end
        end
        if (act == ACT_REFUSE && st_q.refused != INV_MAX) begin
            st_d.refused = st_q.refused + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign counts        = st_q.tally;
    assign invalid_count = st_q.refused;

    p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(counts) && $stable(invalid_count));
    p_inv_sat_r7: assert property (@(posedge clk) disable iff (rst)
        (invalid_count == INV_MAX) |=> (invalid_count == INV_MAX));
    p_no_commit_high_r5: assert property (@(posedge clk) disable iff (rst)
        cast |=> $stable(counts));

    for (genvar g = 0; g < N_CAND; g++) begin : g_sat
        p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
            (counts[g] == CNT_MAX) |=> (counts[g] == CNT_MAX));
    end
endmodule

// File: rtl/vtu_result.sv
module vtu_result #(
    parameter int N_CAND = 4,
    parameter int CNT_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         unlocked,
    input  logic                         close_req,
    input  logic [N_CAND-1:0][CNT_W-1:0] counts,
    output logic                         freeze,
    output logic [N_CAND-1:0]            winner,
    output logic                         tie,
    output logic                         result_valid
);
    typedef struct packed {
        logic              closed;
        logic              valid;
        logic [N_CAND-1:0] win;
        logic              shared;
    } res_t;

    res_t              st_d, st_q;
    logic [CNT_W-1:0]  top;
    logic [N_CAND-1:0] hits;

    always_comb begin
        top = '0;
        for (int i = 0; i < N_CAND; i++) begin
            if (counts[i] > top) begin
                top = counts[i];
            end
        end
        for (int i = 0; i < N_CAND; i++) begin
            hits[i] = (counts[i] == top);
        end
    end

    assign freeze = st_q.closed || (close_req && unlocked);

    always_comb begin
        st_d        = '0;
        st_d.closed = freeze;
        if (freeze) begin
            st_d.valid  = 1'b1;
            st_d.win    = hits;
            st_d.shared = ($countones(hits) > 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign winner       = st_q.win;
    assign tie          = st_q.shared;
    assign result_valid = st_q.valid;

    p_quiet_open_r10: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> (winner == '0) && !tie);
    p_has_winner_r10: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (winner != '0));
    p_valid_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> result_valid && $stable(winner));
    p_locked_no_close_r4: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && !result_valid) |=> !result_valid);
endmodule

// File: rtl/vote_tally_unit.sv
module vote_tally_unit #(
    parameter int               N_CAND    = 4,
    parameter int               CNT_W     = 16,
    parameter int               INV_W     = 8,
    parameter int               KEY_W     = 32,
    parameter logic [KEY_W-1:0] KEY       = vtu_pkg::DEF_KEY,
    parameter int               MAX_TRIES = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    key_valid,
    input  logic [KEY_W-1:0]        key_word,
    input  logic                    cast,
    input  logic [N_CAND-1:0]       sel,
    input  logic                    close_req,
    output logic                    unlocked,
    output logic                    lockout,
    output logic [N_CAND*CNT_W-1:0] vote_counts,
    output logic [INV_W-1:0]        invalid_count,
    output logic [N_CAND-1:0]       winner,
    output logic                    tie,
    output logic                    result_valid
);
    logic                         freeze;
    logic                         accept;
    logic [N_CAND-1:0][CNT_W-1:0] counts;

    vtu_key_gate #(
        .KEY_W(KEY_W), .KEY(KEY), .MAX_TRIES(MAX_TRIES)
    ) u_gate (
        .clk(clk), .rst(rst), .key_valid(key_valid), .key_word(key_word),
        .unlocked(unlocked), .lockout(lockout)
    );

    assign accept = unlocked && !freeze;

    vtu_ballot #(
        .N_CAND(N_CAND), .CNT_W(CNT_W), .INV_W(INV_W)
    ) u_ballot (
        .clk(clk), .rst(rst), .accept(accept), .cast(cast), .sel(sel),
        .counts(counts), .invalid_count(invalid_count)
    );

    vtu_result #(
        .N_CAND(N_CAND), .CNT_W(CNT_W)
    ) u_result (
        .clk(clk), .rst(rst), .unlocked(unlocked), .close_req(close_req),
        .counts(counts), .freeze(freeze), .winner(winner), .tie(tie),
        .result_valid(result_valid)
    );

    assign vote_counts = counts;

    p_locked_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> $stable(vote_counts) && $stable(invalid_count));
endmodule

// File: tb/vote_tally_unit_tb.sv
module vote_tally_unit_tb;
    localparam int          N   = 4;
    localparam int          CW  = 5;
    localparam int          IW  = 3;
    localparam logic [31:0] KEY = 32'hC0DE_5A17;
    localparam int          CMAX = (1 << CW) - 1;
    localparam int          IMAX = (1 << IW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          key_valid = 1'b0;
    logic [31:0]   key_word = '0;
    logic          cast = 1'b0;
    logic [N-1:0]  sel = '0;
    logic          close_req = 1'b0;
    logic          unlocked, lockout, tie, result_valid;
    logic [N*CW-1:0] vote_counts;
    logic [IW-1:0] invalid_count;
    logic [N-1:0]  winner;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit started = 1'b0;

    // reference model state
    bit         m_unl, m_lock, m_castq, m_closed, m_valid, m_tie;
    int         m_fails, m_inv;
    int         m_cnt [N];
    logic [N-1:0] m_hold, m_win;

    always #5 clk = ~clk;

    vote_tally_unit #(.N_CAND(N), .CNT_W(CW), .INV_W(IW), .KEY(KEY)) u_dut (
        .clk(clk), .rst(rst), .key_valid(key_valid), .key_word(key_word),
        .cast(cast), .sel(sel), .close_req(close_req), .unlocked(unlocked),
        .lockout(lockout), .vote_counts(vote_counts), .invalid_count(invalid_count),
        .winner(winner), .tie(tie), .result_valid(result_valid)
    );

    function automatic int cnt_of(int i);
        return int'(vote_counts[i*CW +: CW]);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit o_unl, close_now;
        int top;
        cycles++;
        started = 1'b1;
        if (rst) begin
            m_unl = 0; m_lock = 0; m_castq = 0; m_closed = 0; m_valid = 0; m_tie = 0;
            m_fails = 0; m_inv = 0; m_hold = '0; m_win = '0;
            for (int i = 0; i < N; i++) m_cnt[i] = 0;
        end else begin
            o_unl = m_unl;
            if (key_valid && !o_unl && !m_lock) begin
                if (key_word == KEY) begin
                    m_unl = 1; m_fails = 0;
                end else begin
                    m_fails++;
                    if (m_fails >= 3) m_lock = 1;
                end
            end
            close_now = m_closed || (close_req && o_unl);
            if (m_castq && !cast && o_unl && !close_now) begin
                if ($countones(m_hold) == 1) begin
                    for (int i = 0; i < N; i++)
                        if (m_hold[i] && m_cnt[i] < CMAX) m_cnt[i]++;
                end else if (m_inv < IMAX) begin
                    m_inv++;
                end
            end
            m_closed = close_now;
            m_valid = close_now;
            m_win = '0;
            m_tie = 0;
            if (close_now) begin
                top = 0;
                for (int i = 0; i < N; i++) if (m_cnt[i] > top) top = m_cnt[i];
                for (int i = 0; i < N; i++) m_win[i] = (m_cnt[i] == top);
                m_tie = ($countones(m_win) > 1);
            end
            if (cast) m_hold = sel;
            m_castq = cast;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk(unlocked == m_unl, "R2 unlocked", int'(unlocked), int'(m_unl));
            chk(lockout == m_lock, "R3 lockout", int'(lockout), int'(m_lock));
            for (int i = 0; i < N; i++)
                chk(cnt_of(i) == m_cnt[i], "R5 tally", cnt_of(i), m_cnt[i]);
            chk(int'(invalid_count) == m_inv, "R7 invalid_count", int'(invalid_count), m_inv);
            chk(winner == m_win, "R10 winner", int'(winner), int'(m_win));
            chk(tie == m_tie, "R10 tie", int'(tie), int'(m_tie));
            chk(result_valid == m_valid, "R10 result_valid", int'(result_valid), int'(m_valid));
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(logic [N-1:0] s, int hi);
        @(negedge clk);
        sel = s; cast = 1'b1;
        tick(hi);
        cast = 1'b0;
        tick(1);
    endtask

    task automatic try_key(logic [31:0] k);
        @(negedge clk);
        key_valid = 1'b1; key_word = k;
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    task automatic close_now();
        @(negedge clk);
        close_req = 1'b1;
        @(negedge clk);
        close_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        chk(!unlocked && !lockout && !result_valid && winner == 0 && !tie &&
            vote_counts == 0 && invalid_count == 0, "R1 reset state",
            int'(vote_counts), 0);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        chk(vote_counts == 0 && !unlocked, "R1 initial reset", int'(vote_counts), 0);

        // locked: ballots and close ignored
        pulse(4'b0001, 1);
        pulse(4'b0000, 1);
        close_now();
        tick(1);
        chk(cnt_of(0) == 0 && invalid_count == 0 && !result_valid, "R4 locked ignores",
            cnt_of(0), 0);

        // wrong, wrong, right: consecutive count cleared
        try_key(32'h1234_5678);
        try_key(32'hC0DE_5A16);
        try_key(KEY);
        tick(1);
        chk(unlocked && !lockout, "R2 unlock after two misses", int'(unlocked), 1);
        try_key(32'h0);
        try_key(32'h0);
        try_key(32'h0);
        tick(1);
        chk(unlocked && !lockout, "R11 keys ignored once open", int'(lockout), 0);

        pulse(4'b0001, 1);
        pulse(4'b0001, 2);
        pulse(4'b0001, 1);
        pulse(4'b0010, 1);
        pulse(4'b0010, 4);
        chk(cnt_of(1) == 2, "R6 long pulse counts once", cnt_of(1), 2);
        pulse(4'b0010, 1);
        // selection changes while high: last high-cycle selection counts
        @(negedge clk);
        sel = 4'b0001; cast = 1'b1;
        @(negedge clk);
        sel = 4'b0100;
        @(negedge clk);
        cast = 1'b0; sel = 4'b0001;
        tick(1);
        chk(cnt_of(2) == 1 && cnt_of(0) == 3, "R5 last high selection", cnt_of(2), 1);
        pulse(4'b0000, 1);
        pulse(4'b0110, 2);
        chk(invalid_count == 2, "R7 refused selections", int'(invalid_count), 2);
        for (int k = 0; k < 10; k++) pulse(4'b1111, 1);
        chk(int'(invalid_count) == IMAX, "R7 invalid saturates", int'(invalid_count), IMAX);
        for (int k = 0; k < CMAX + 9; k++) pulse(4'b1000, 1);
        chk(cnt_of(3) == CMAX, "R8 tally saturates", cnt_of(3), CMAX);

        // close while a pulse falls in the same cycle
        @(negedge clk);
        sel = 4'b0001; cast = 1'b1;
        @(negedge clk);
        cast = 1'b0; close_req = 1'b1;
        @(negedge clk);
        close_req = 1'b0;
        chk(cnt_of(0) == 3 && result_valid, "R9 fall with close ignored", cnt_of(0), 3);
        chk(winner == 4'b1000 && !tie, "R10 clear leader", int'(winner), 8);
        pulse(4'b0010, 1);
        pulse(4'b0000, 1);
        chk(cnt_of(1) == 3 && result_valid, "R9 frozen after close", cnt_of(1), 3);

        // two-way tie
        do_reset();
        try_key(KEY);
        pulse(4'b0001, 1);
        pulse(4'b0010, 1);
        pulse(4'b0001, 1);
        pulse(4'b0100, 1);
        pulse(4'b0010, 2);
        close_now();
        chk(winner == 4'b0011 && tie, "R10 two-way tie", int'(winner), 3);

        // all zero
        do_reset();
        try_key(KEY);
        close_now();
        chk(winner == 4'b1111 && tie, "R10 all-zero tie", int'(winner), 15);

        // lockout
        do_reset();
        try_key(32'hDEAD_BEEF);
        try_key(32'hDEAD_BEEF);
        try_key(32'hDEAD_BEEF);
        tick(1);
        chk(lockout && !unlocked, "R3 lockout after three", int'(lockout), 1);
        try_key(KEY);
        pulse(4'b0001, 1);
        close_now();
        tick(1);
        chk(lockout && !unlocked && cnt_of(0) == 0 && !result_valid,
            "R3 lockout holds against correct key", int'(unlocked), 0);
        do_reset();
        chk(!lockout, "R1 reset clears lockout", int'(lockout), 0);

        tick(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule